// File: doc/BRIEF.md
# Deferred Condition-Code Flag Evaluator

This block turns a saved operation tag, a saved result and a saved source operand into the four processor status flags: negative, zero, overflow and carry. Carry and overflow are rebuilt from the result and the source alone. For example, an addition recovers its first operand as result minus source, and a subtraction recovers it as result plus source. Byte and word compares evaluate every flag at their own width. Shifts take carry from whether the saved source value is nonzero.

The block also holds the extend bit and performs add-with-extend and subtract-with-extend itself. The held extend bit chooses between the plain and the extended form. The carry or borrow produced becomes the new extend bit. In these two operations the zero flag is sticky: a nonzero result clears it and a zero result cannot set it again. The evaluated flag word is registered on a commit strobe, so it stays resolved until the next commit.

Top module: `ccf_resolver`

## Requirements
- R1: While rst_ni is low, flags_o reads 4'b0000 and x_o reads 0. The flag word packs carry in bit 0, overflow in bit 1, zero in bit 2 and negative in bit 3.
- R2: A commit with op_i = 0 (resolved) loads a_i[3:0] unchanged into flags_o.
- R3: Tag 1 (logic) sets only N and Z from a_i, with V = C = 0. Z takes priority: N is 0 whenever the value is zero, and otherwise N is its bit 31.
- R4: Tag 2 (add; a_i = result, b_i = source) sets C when result < source (unsigned). V is set when source and result differ in sign and the rebuilt operand (result - source) has the same sign as the source.
- R5: Tag 3 (subtract) rebuilds the operand t = result + source. C is set when t < source (unsigned). V is bit 31 of (t ^ result) & (t ^ source).
- R6: Tag 4 (byte compare) and tag 5 (word compare) apply the subtract rule using only the low 8 or 16 bits. N and Z come from the result sign-extended from that width, and V and C use bit 7 or bit 15.
- R7: Tag 6 (add-extended, deferred) sets C when result <= source. Tag 7 (subtract-extended, deferred) sets C when result + source + 1 <= source. N and Z are set as in R3 for both.
- R8: Tag 8 (shift) sets C exactly when b_i is nonzero, with V = 0, and N and Z as in R3.
- R9: Tag 9 computes result_o = a_i + b_i + x_o, and tag 10 computes result_o = a_i - b_i - x_o. On commit, both evaluate flags as add/add-extended or subtract/subtract-extended according to x_o, and load the new carry into x_o. No other tag changes x_o.
- R10: After a commit of tag 9 or 10, Z is set only if the new result is zero and Z was already set.
- R11: Tags 11 to 15 are illegal. illegal_o is high during such a commit, and flags_o and x_o keep their values.
- R12: Without commit_i, flags_o and x_o hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| commit_i | input | 1 | Evaluate and register flags this cycle |
| op_i | input | 4 | Operation tag |
| a_i | input | 32 | Saved result (deferred tags) or first operand (tags 9, 10) |
| b_i | input | 32 | Saved source operand or second operand |
| result_o | output | 32 | Computed sum or difference for tags 9 and 10, a_i otherwise |
| flags_o | output | 4 | Registered flags {N, Z, V, C} |
| x_o | output | 1 | Registered extend bit |
| illegal_o | output | 1 | Commit with an unsupported tag |

## Verification
The hardest state to reach is a multi-precision chain, where the outcome depends on the extend bit and zero flag left behind by earlier commits. The bench seeds Z through a resolved-flags commit. It then forces a carry out of an extended add so that x_o becomes 1, and runs extended adds and subtracts in sequence. This shows that a zero result after a nonzero one leaves Z clear, and that Z survives only while every step is zero. The compare-width vectors put nonzero upper bits next to zero or borderline low bytes and halfwords, so that flags evaluated at the full width would give different answers.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  typedef enum logic [3:0] {
    TAG_RESOLVED = 4'd0,
    TAG_LOGIC    = 4'd1,
    TAG_ADD      = 4'd2,
    TAG_SUB      = 4'd3,
    TAG_CMP8     = 4'd4,
    TAG_CMP16    = 4'd5,
    TAG_ADDX     = 4'd6,
    TAG_SUBX     = 4'd7,
    TAG_SHIFT    = 4'd8,
    TAG_XADD_RUN = 4'd9,
    TAG_XSUB_RUN = 4'd10
  } tag_e;

  localparam int unsigned FLAG_C = 0;
  localparam int unsigned FLAG_V = 1;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_W = 4;
endpackage

// File: rtl/ccf_ext_unit.sv
module ccf_ext_unit
  import ccf_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          x_i,
  output logic [3:0]    tag_o,
  output logic [DW-1:0] dst_o,
  output logic          run_o
);
  logic [DW-1:0] x_ext;
  assign x_ext = DW'(x_i);

  always_comb begin
    tag_o = op_i;
    dst_o = a_i;
    run_o = 1'b0;
    case (op_i)
      TAG_XADD_RUN: begin
        run_o = 1'b1;
        dst_o = a_i + b_i + x_ext;
        tag_o = x_i ? TAG_ADDX : TAG_ADD;
      end
      TAG_XSUB_RUN: begin
        run_o = 1'b1;
        dst_o = a_i - b_i - x_ext;
        tag_o = x_i ? TAG_SUBX : TAG_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ccf_flag_calc.sv
module ccf_flag_calc
  import ccf_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [3:0]        tag_i,
  input  logic [DW-1:0]     dst_i,
  input  logic [DW-1:0]     src_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              valid_o
);
  localparam int unsigned NCMP = 2;
  localparam int unsigned CMP_W [NCMP] = '{8, 16};

  function automatic logic top_bit(input logic [DW-1:0] v);
    return v[DW-1];
  endfunction

  logic [DW-1:0] sum0, sum1;
  assign sum0 = dst_i + src_i;
  assign sum1 = dst_i + src_i + DW'(1);

  logic z_full, n_full;
  assign z_full = (dst_i == '0);
  assign n_full = !z_full && dst_i[DW-1];

  // narrow compares: rebuild operand at the compare width
  logic [FLAG_W-1:0] cmp_flags [NCMP];
  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    localparam int unsigned CW = CMP_W[g];
    logic [CW-1:0] nd, ns, nt;
    logic nz;
    assign nd = dst_i[CW-1:0];
    assign ns = src_i[CW-1:0];
    assign nt = nd + ns;
    assign nz = (nd == '0);
    assign cmp_flags[g][FLAG_Z] = nz;
    assign cmp_flags[g][FLAG_N] = !nz && nd[CW-1];
    assign cmp_flags[g][FLAG_C] = (nt < ns);
    assign cmp_flags[g][FLAG_V] = (nt[CW-1] ^ nd[CW-1]) & (nt[CW-1] ^ ns[CW-1]);
  end

  always_comb begin
    flags_o         = '0;
    valid_o         = 1'b1;
    flags_o[FLAG_Z] = z_full;
    flags_o[FLAG_N] = n_full;
    case (tag_i)
      TAG_RESOLVED: flags_o = dst_i[FLAG_W-1:0];
      TAG_LOGIC: ;
      TAG_ADD: begin
        flags_o[FLAG_C] = (dst_i < src_i);
        flags_o[FLAG_V] = top_bit((src_i ^ dst_i) & ~((dst_i - src_i) ^ src_i));
      end
      TAG_SUB: begin
        flags_o[FLAG_C] = (sum0 < src_i);
        flags_o[FLAG_V] = top_bit((sum0 ^ dst_i) & (sum0 ^ src_i));
      end
      TAG_CMP8:  flags_o = cmp_flags[0];
      TAG_CMP16: flags_o = cmp_flags[1];
      TAG_ADDX: begin
        flags_o[FLAG_C] = (dst_i <= src_i);
        flags_o[FLAG_V] = top_bit((src_i ^ dst_i) & ~((dst_i - src_i - DW'(1)) ^ src_i));
      end
      TAG_SUBX: begin
        flags_o[FLAG_C] = (sum1 <= src_i);
        flags_o[FLAG_V] = top_bit((sum1 ^ dst_i) & (sum1 ^ src_i));
      end
      TAG_SHIFT: flags_o[FLAG_C] = (src_i != '0);
      default: begin
        flags_o = '0;
        valid_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ccf_resolver.sv
module ccf_resolver
  import ccf_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [3:0]        op_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     b_i,
  output logic [DW-1:0]     result_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              x_o,
  output logic              illegal_o
);
  logic [FLAG_W-1:0] flags_q, calc_flags, next_flags;
  logic              x_q, run, valid;
  logic [3:0]        eval_tag;
  logic [DW-1:0]     dst;

  ccf_ext_unit #(.DW(DW)) i_ext (
    .op_i  (op_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .x_i   (x_q),
    .tag_o (eval_tag),
    .dst_o (dst),
    .run_o (run)
  );

  ccf_flag_calc #(.DW(DW)) i_calc (
    .tag_i   (eval_tag),
    .dst_i   (dst),
    .src_i   (b_i),
    .flags_o (calc_flags),
    .valid_o (valid)
  );

  // extended arithmetic: zero can only be kept, never raised
  always_comb begin
    next_flags = calc_flags;
    if (run) next_flags[FLAG_Z] = calc_flags[FLAG_Z] & flags_q[FLAG_Z];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      x_q     <= 1'b0;
    end else if (commit_i && valid) begin
      flags_q <= next_flags;
      if (run) x_q <= next_flags[FLAG_C];
    end
  end

  assign result_o  = dst;
  assign flags_o   = flags_q;
  assign x_o       = x_q;
  assign illegal_o = commit_i & ~valid;
endmodule

// File: rtl/ccf_resolver_chk.sv
module ccf_resolver_chk
  import ccf_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              commit_i,
  input logic [3:0]        op_i,
  input logic [DW-1:0]     b_i,
  input logic [FLAG_W-1:0] flags_o,
  input logic              x_o,
  input logic              illegal_o
);
  logic is_run;
  assign is_run = (op_i == TAG_XADD_RUN) || (op_i == TAG_XSUB_RUN);

  // R11
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> (flags_o == $past(flags_o)) && (x_o == $past(x_o)));

  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(flags_o) && $stable(x_o));

  // R10
  sticky_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && is_run && !flags_o[FLAG_Z]) |=> !flags_o[FLAG_Z]);

  // R9
  x_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_i && is_run) |=> $stable(x_o));

  // R9
  x_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && is_run) |=> (x_o == flags_o[FLAG_C]));

  // R3
  logic_vc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && op_i == TAG_LOGIC) |=> (flags_o[FLAG_V] == 1'b0) && (flags_o[FLAG_C] == 1'b0));

  // R8
  shift_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && op_i == TAG_SHIFT) |=> (flags_o[FLAG_C] == ($past(b_i) != '0)));

  // R3
  nz_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && op_i != TAG_RESOLVED && !illegal_o) |=> !(flags_o[FLAG_N] && flags_o[FLAG_Z]));
endmodule

bind ccf_resolver ccf_resolver_chk #(.DW(DW)) i_ccf_resolver_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .commit_i  (commit_i),
  .op_i      (op_i),
  .b_i       (b_i),
  .flags_o   (flags_o),
  .x_o       (x_o),
  .illegal_o (illegal_o)
);

// File: tb/test_ccf_resolver.sv
`timescale 1ns/1ps
module test_ccf_resolver;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        commit_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [31:0] result_o;
  logic [3:0]  flags_o;
  logic        x_o, illegal_o;
  int          n_run = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  ccf_resolver i_ccf_resolver (.*);

  // {tag, a (result), b (source), expected {N,Z,V,C}}
  localparam int NV = 21;
  localparam logic [71:0] VEC [NV] = '{
    {4'd0, 32'h0000000B, 32'h00000000, 4'b1011},
    {4'd1, 32'h00000000, 32'hDEADBEEF, 4'b0100},
    {4'd1, 32'h80000000, 32'h00000000, 4'b1000},
    {4'd2, 32'h00000001, 32'h00000002, 4'b0001},
    {4'd2, 32'h80000000, 32'h00000001, 4'b1010},
    {4'd2, 32'h00000005, 32'h00000003, 4'b0000},
    {4'd3, 32'h00000000, 32'h00000005, 4'b0100},
    {4'd3, 32'hFFFFFFFE, 32'h00000005, 4'b1001},
    {4'd3, 32'h7FFFFFFF, 32'h00000001, 4'b0010},
    {4'd4, 32'h12345680, 32'h00000001, 4'b1000},
    {4'd4, 32'hABCD0000, 32'h00000010, 4'b0100},
    {4'd4, 32'h0000007F, 32'h00000001, 4'b0010},
    {4'd4, 32'h000000FF, 32'h00000002, 4'b1001},
    {4'd5, 32'h00008000, 32'h00000000, 4'b1000},
    {4'd5, 32'h00010000, 32'h00000000, 4'b0100},
    {4'd5, 32'h00007FFF, 32'h00000001, 4'b0010},
    {4'd6, 32'h00000002, 32'h00000002, 4'b0001},
    {4'd7, 32'h00000000, 32'hFFFFFFFF, 4'b0101},
    {4'd8, 32'h00000040, 32'h00000000, 4'b0000},
    {4'd8, 32'h00000000, 32'h00000005, 4'b0101},
    {4'd8, 32'h80000000, 32'h00000001, 4'b1001}
  };

  function automatic string req_of(input logic [3:0] t);
    case (t)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4, 4'd5: return "R6";
      4'd6, 4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, sample combinational outputs mid-cycle, registered ones after the edge
  task automatic commit(input logic [3:0] t, input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] res, output logic ill);
    @(negedge clk_i);
    op_i = t; a_i = a; b_i = b; commit_i = 1'b1;
    #1;
    res = result_o; ill = illegal_o;
    @(negedge clk_i);
    commit_i = 1'b0;
    #1;
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic        il;
    #20;
    check("R1", {28'd0, flags_o}, 32'h0);
    check("R1", {31'd0, x_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      commit(VEC[i][71:68], VEC[i][67:36], VEC[i][35:4], r, il);
      check(req_of(VEC[i][71:68]), {28'd0, flags_o}, {28'd0, VEC[i][3:0]});
      check("R9", {31'd0, x_o}, 32'h0);
    end

    // extended arithmetic chain
    commit(4'd0, 32'h4, 32'h0, r, il);
    commit(4'd9, 32'hFFFFFFFF, 32'h1, r, il);
    check("R9", r, 32'h0);
    check("R10", {28'd0, flags_o}, 32'h5);
    check("R9", {31'd0, x_o}, 32'h1);
    commit(4'd9, 32'h0, 32'h0, r, il);
    check("R9", r, 32'h1);
    check("R9", {28'd0, flags_o}, 32'h0);
    check("R9", {31'd0, x_o}, 32'h0);
    commit(4'd9, 32'h0, 32'h0, r, il);
    check("R9", r, 32'h0);
    check("R10", {28'd0, flags_o}, 32'h0);
    commit(4'd10, 32'h1, 32'h2, r, il);
    check("R9", r, 32'hFFFFFFFF);
    check("R9", {28'd0, flags_o}, 32'h9);
    check("R9", {31'd0, x_o}, 32'h1);
    commit(4'd10, 32'h5, 32'h4, r, il);
    check("R9", r, 32'h0);
    check("R10", {28'd0, flags_o}, 32'h0);
    check("R9", {31'd0, x_o}, 32'h0);
    commit(4'd0, 32'h4, 32'h0, r, il);
    commit(4'd10, 32'h7, 32'h7, r, il);
    check("R10", {28'd0, flags_o}, 32'h4);
    check("R9", {31'd0, x_o}, 32'h0);

    // illegal tag
    commit(4'd15, 32'hFFFFFFFF, 32'h1, r, il);
    check("R11", {31'd0, il}, 32'h1);
    check("R11", {28'd0, flags_o}, 32'h4);
    check("R11", {31'd0, x_o}, 32'h0);
    commit(4'd11, 32'h0, 32'h0, r, il);
    check("R11", {31'd0, il}, 32'h1);
    check("R11", {28'd0, flags_o}, 32'h4);

    // no commit
    @(negedge clk_i);
    op_i = 4'd0; a_i = 32'hF; commit_i = 1'b0;
    repeat (3) @(negedge clk_i);
    #1;
    check("R12", {28'd0, flags_o}, 32'h4);
    check("R11", {31'd0, illegal_o}, 32'h0);

    // reset mid-run
    commit(4'd9, 32'hFFFFFFFF, 32'h1, r, il);
    check("R9", {31'd0, x_o}, 32'h1);
    rst_ni = 1'b0;
    #1;
    check("R1", {28'd0, flags_o}, 32'h0);
    check("R1", {31'd0, x_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule